// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block is a slave port through which a host processor reads and writes a small bank of configuration registers. The host bus can take either of two forms, picked at run time by a style-select input. In split-strobe form the host drives separate active-low read and write strobes. In direction-strobe form a direction line gives read or write, and an active-low data strobe marks the access. Both forms share a multiplexed address bus that is captured when the address-latch input falls. Every access is gated by an active-low chip select.

The port runs on an internal clock that is independent of the host. Every bus control input passes through a two-stage synchronizer before any decision is made, so the host may run with or without its own clock. A write takes effect when the qualifying strobe is released, using the data present on the bus at that moment. During a read the port drives data and raises its output enable. A mode input puts the port in hardware mode. In that mode the port ignores the bus and the registers keep their values.

Top module: `hbr_regport`

## Requirements
- R1: While `hw_mode` is 1 (hardware mode), strobes and address latches are ignored, no register changes and `data_oe` stays 0. While `hw_mode` is 0 (host mode), the bus is served.
- R2: While `cs_n` is 1, no access takes place: no register is written and `data_oe` stays 0.
- R3: With `proc_sel` = 0 (split-strobe style), a low pulse on `wr_rw` with `cs_n` low writes the register at the latched address. The value stored is the `data_in` present when the strobe is released.
- R4: With `proc_sel` = 0, holding `rd_ds` low with `cs_n` low drives the register at the latched address onto `data_out` and sets `data_oe` to 1.
- R5: With `proc_sel` = 1 (direction-strobe style), `rd_ds` is the active-low data strobe and `wr_rw` gives the direction: 1 reads and 0 writes. Reads and writes otherwise behave as in R3 and R4.
- R6: The address is taken from `addr_in` on the falling edge of `ale`, in either style. Later changes of `addr_in` have no effect until the next falling edge.
- R7: Addresses 0 to NREG-1 (32 by default) are read/write registers that reset to 0. Reads of any higher address return 0 with `data_oe` high. Writes to a higher address change no register.
- R8: `data_oe` rises three clock edges after the read strobe goes low at the pin. It stays high exactly two clock edges after the strobe is released at the pin and is low after the third edge. `data_out` and `data_oe` are 0 after reset.
- R9: If `proc_sel` or `hw_mode` changes while an access is under way, that access is aborted and no register is modified, even if the strobe state in the new style still looks active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_mode | input | 1 | 1 = hardware mode (port disabled), 0 = host mode |
| proc_sel | input | 1 | Bus style: 0 = split strobes, 1 = direction plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch strobe; address taken on falling edge |
| wr_rw | input | 1 | Write strobe (split) or direction line (direction-strobe) |
| rd_ds | input | 1 | Read strobe (split) or data strobe (direction-strobe) |
| addr_in | input | AW | Multiplexed address bus |
| data_in | input | DW | Write data from host |
| data_out | output | DW | Read data to host |
| data_oe | output | 1 | Read data output enable |

## Verification
The main test writes a computed value to every address from 0 to 39. Each write uses one style and each read-back uses the other, which shows that both styles decode the same register and catches a style that writes or reads the wrong place. Addresses above the bank check that such writes do not alias onto a real register. A later full read of the bank separates lost writes from aliased ones. Directed patterns cover the remaining cases: data changed while the strobe is held, address changed after the latch, chip select held high, hardware mode, and a style or mode change in the middle of a write. The release of the read enable is sampled edge by edge to pin down its latency.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   typedef enum logic {
      BUS_SPLIT  = 1'b0,
      BUS_DIRSTB = 1'b1
   } bus_style_e;

   // synchronized control pins, one bit each
   typedef struct packed {
      logic hw;
      logic sel;
      logic cs_n;
      logic ale;
      logic s0;   // write strobe or direction line
      logic s1;   // read strobe or data strobe
   } pins_t;

   localparam int PINS_W = $bits(pins_t);
   localparam pins_t PINS_IDLE = '{hw: 1'b1, sel: 1'b0, cs_n: 1'b1,
                                   ale: 1'b0, s0: 1'b1, s1: 1'b1};

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
   parameter int            W      = 1,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= RST;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= RST;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
   import hbr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  pins_t p,
   output logic  wr_act,
   output logic  rd_act,
   output logic  wr_commit,
   output logic  ale_fall,
   output logic  cfg_chg
);

   logic split_wr, split_rd, dstb, dir_wr, dir_rd;
   logic hw_q, sel_q, ale_q, acc_wr_q, acc_rd_q, abort_q;
   logic busy;

   always_comb begin
      split_wr = ~p.s0 & ~p.cs_n;
      split_rd = ~p.s1 & ~p.cs_n;
      dstb     = ~p.s1 & ~p.cs_n;
      dir_wr   = dstb & ~p.s0;
      dir_rd   = dstb &  p.s0;
      if (bus_style_e'(p.sel) == BUS_DIRSTB) begin
         wr_act = ~p.hw & dir_wr;
         rd_act = ~p.hw & dir_rd;
      end else begin
         wr_act = ~p.hw & split_wr;
         rd_act = ~p.hw & split_rd;
      end
      cfg_chg   = (p.hw != hw_q) | (p.sel != sel_q);
      busy      = wr_act | rd_act | acc_wr_q | acc_rd_q;
      wr_commit = acc_wr_q & ~wr_act & ~abort_q & ~cfg_chg;
      ale_fall  = ~p.hw & ale_q & ~p.ale;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw_q     <= 1'b1;
         sel_q    <= 1'b0;
         ale_q    <= 1'b0;
         acc_wr_q <= 1'b0;
         acc_rd_q <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         hw_q     <= p.hw;
         sel_q    <= p.sel;
         ale_q    <= p.ale;
         acc_wr_q <= wr_act;
         acc_rd_q <= rd_act;
         abort_q  <= busy ? (abort_q | cfg_chg) : 1'b0;
      end
   end

endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile #(
   parameter int AW   = 8,
   parameter int DW   = 8,
   parameter int NREG = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   if (NREG < 1 || NREG > (1 << AW)) begin : g_bad_depth
      $error("hbr_regfile: NREG must lie in 1 .. 2**AW");
   end

   logic [DW-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          regs[i] <= '0;
         else if (we && waddr == AW'(i))      regs[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (raddr == AW'(i)) rdata = regs[i];
      end
   end

endmodule

// File: rtl/hbr_regport.sv
module hbr_regport
   import hbr_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int NREG        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hw_mode,
   input  logic          proc_sel,
   input  logic          cs_n,
   input  logic          ale,
   input  logic          wr_rw,
   input  logic          rd_ds,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_out,
   output logic          data_oe
);

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("hbr_regport: AW and DW must be positive");
   end

   pins_t         pin_raw, pin_s;
   logic          wr_act, rd_act, wr_commit, ale_fall, cfg_chg;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] rdata, dout_q;
   logic          oe_q;

   assign pin_raw = '{hw: hw_mode, sel: proc_sel, cs_n: cs_n,
                      ale: ale, s0: wr_rw, s1: rd_ds};

   hbr_sync #(
      .W      (PINS_W),
      .STAGES (SYNC_STAGES),
      .RST    (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   hbr_decode u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .p         (pin_s),
      .wr_act    (wr_act),
      .rd_act    (rd_act),
      .wr_commit (wr_commit),
      .ale_fall  (ale_fall),
      .cfg_chg   (cfg_chg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (ale_fall) addr_q <= addr_in;
   end

   hbr_regfile #(
      .AW   (AW),
      .DW   (DW),
      .NREG (NREG)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_commit),
      .waddr (addr_q),
      .wdata (data_in),
      .raddr (addr_q),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         dout_q <= '0;
      end else begin
         oe_q   <= rd_act;
         dout_q <= rd_act ? rdata : '0;
      end
   end

   assign data_out = dout_q;
   assign data_oe  = oe_q;

endmodule

// File: rtl/hbr_regport_chk.sv
module hbr_regport_chk #(
   parameter int AW   = 8,
   parameter int DW   = 8,
   parameter int NREG = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hw_mode,
   input logic          cs_n,
   input logic          data_oe,
   input logic [DW-1:0] data_out,
   input logic [AW-1:0] addr_q,
   input logic          rd_act,
   input logic          wr_act,
   input logic          wr_commit
);

   a_r1_hw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_mode && $past(hw_mode) && $past(hw_mode, 2) && $past(hw_mode, 3))
      |-> !data_oe);

   a_r2_cs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> !data_oe);

   a_r3_commit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(wr_act));

   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && $past(rd_act) && $stable(addr_q) && (int'(addr_q) >= NREG))
      |-> (data_out == '0));

   a_r8_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |=> data_oe);

   a_r8_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_act) |=> !data_oe);

endmodule

bind hbr_regport hbr_regport_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hw_mode   (hw_mode),
   .cs_n      (cs_n),
   .data_oe   (data_oe),
   .data_out  (data_out),
   .addr_q    (addr_q),
   .rd_act    (rd_act),
   .wr_act    (wr_act),
   .wr_commit (wr_commit)
);

// File: tb/test_hbr_regport.sv
module test_hbr_regport;

   localparam int AW   = 8;
   localparam int DW   = 8;
   localparam int NREG = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hw_mode = 1'b1;
   logic          proc_sel = 1'b0;
   logic          cs_n = 1'b1;
   logic          ale = 1'b0;
   logic          wr_rw = 1'b1;
   logic          rd_ds = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] data_in = '0;
   logic [DW-1:0] data_out;
   logic          data_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   hbr_regport #(.AW(AW), .DW(DW), .NREG(NREG)) i_hbr_regport (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_mode  (hw_mode),
      .proc_sel (proc_sel),
      .cs_n     (cs_n),
      .ale      (ale),
      .wr_rw    (wr_rw),
      .rd_ds    (rd_ds),
      .addr_in  (addr_in),
      .data_in  (data_in),
      .data_out (data_out),
      .data_oe  (data_oe)
   );

   function automatic logic [7:0] pat(input int a, input int k);
      return 8'((a * 37 + k * 11 + 5) & 255);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic latch_addr(input logic [7:0] a);
      @(negedge clk);
      addr_in = a;
      ale = 1'b1;
      wait_n(3);
      ale = 1'b0;
      wait_n(4);
   endtask

   // style 0: split strobes, style 1: direction + data strobe
   task automatic strobe_on(input bit style, input bit rd);
      cs_n = 1'b0;
      if (style == 1'b0) begin
         if (rd) rd_ds = 1'b0;
         else    wr_rw = 1'b0;
      end else begin
         wr_rw = rd;
         wait_n(1);
         rd_ds = 1'b0;
      end
   endtask

   task automatic strobe_off();
      rd_ds = 1'b1;
      wr_rw = 1'b1;
      cs_n  = 1'b1;
   endtask

   task automatic do_write(input bit style, input logic [7:0] a, input logic [7:0] d);
      proc_sel = style;
      latch_addr(a);
      data_in = d;
      strobe_on(style, 1'b0);
      wait_n(4);
      strobe_off();
      wait_n(5);
   endtask

   task automatic do_read(input bit style, input logic [7:0] a,
                          output logic [7:0] v, output logic oe);
      proc_sel = style;
      latch_addr(a);
      strobe_on(style, 1'b1);
      wait_n(5);
      v  = data_out;
      oe = data_oe;
      strobe_off();
      wait_n(5);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      logic       oe;
      logic [7:0] mem [NREG];

      for (int i = 0; i < NREG; i++) mem[i] = '0;

      wait_n(4);
      check("R8 reset data_oe", {7'd0, data_oe}, 8'd0);
      check("R8 reset data_out", data_out, 8'd0);
      rst_n = 1'b1;
      wait_n(3);

      // R1: hardware mode ignores the bus (hw_mode still 1 here)
      do_write(1'b0, 8'd2, 8'hAA);
      proc_sel = 1'b0;
      latch_addr(8'd2);
      strobe_on(1'b0, 1'b1);
      wait_n(5);
      check("R1 hw mode data_oe", {7'd0, data_oe}, 8'd0);
      strobe_off();
      wait_n(5);
      hw_mode = 1'b0;
      wait_n(4);
      do_read(1'b0, 8'd2, v, oe);
      check("R1 hw mode write ignored", v, 8'd0);

      // R7: reset contents are zero
      for (int a = 0; a < NREG; a += 7) begin
         do_read(1'b1, 8'(a), v, oe);
         check("R7 reset value", v, 8'd0);
      end

      // R3 R4 R5 R7: write every address in one style, read back in the other
      for (int a = 0; a < NREG + 8; a++) begin
         bit st = 1'(a & 1);
         do_write(st, 8'(a), pat(a, 1));
         if (a < NREG) mem[a] = pat(a, 1);
         do_read(~st, 8'(a), v, oe);
         check(st ? "R5 dir write / R4 split read" : "R3 split write / R5 dir read",
               v, (a < NREG) ? pat(a, 1) : 8'd0);
         check("R4 R5 data_oe during read", {7'd0, oe}, 8'd1);
      end

      // R7: upper writes did not alias onto the bank
      for (int a = 0; a < NREG; a++) begin
         do_read(1'(a % 3 == 0), 8'(a), v, oe);
         check("R7 bank intact after unmapped writes", v, mem[a]);
      end

      // R6: address held after the latch falls
      proc_sel = 1'b0;
      latch_addr(8'd3);
      addr_in = 8'd9;
      data_in = 8'h5A;
      strobe_on(1'b0, 1'b0);
      wait_n(4);
      strobe_off();
      wait_n(5);
      mem[3] = 8'h5A;
      do_read(1'b0, 8'd3, v, oe);
      check("R6 latched address used", v, 8'h5A);
      do_read(1'b0, 8'd9, v, oe);
      check("R6 other address untouched", v, mem[9]);

      // R3: data value at strobe release is stored
      latch_addr(8'd6);
      data_in = 8'h01;
      strobe_on(1'b0, 1'b0);
      wait_n(3);
      data_in = 8'hC3;
      wait_n(3);
      strobe_off();
      wait_n(5);
      mem[6] = 8'hC3;
      do_read(1'b1, 8'd6, v, oe);
      check("R3 data at release", v, 8'hC3);

      // R2: chip select high blocks write and read
      latch_addr(8'd6);
      data_in = 8'h77;
      wr_rw = 1'b0;
      wait_n(6);
      wr_rw = 1'b1;
      wait_n(5);
      proc_sel = 1'b0;
      rd_ds = 1'b0;
      wait_n(6);
      check("R2 cs high data_oe", {7'd0, data_oe}, 8'd0);
      rd_ds = 1'b1;
      wait_n(5);
      do_read(1'b0, 8'd6, v, oe);
      check("R2 cs high write blocked", v, 8'hC3);

      // R8: enable release timing
      proc_sel = 1'b0;
      latch_addr(8'd6);
      strobe_on(1'b0, 1'b1);
      wait_n(6);
      rd_ds = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R8 oe after two edges", {7'd0, data_oe}, 8'd1);
      @(posedge clk); @(negedge clk);
      check("R8 oe after three edges", {7'd0, data_oe}, 8'd0);
      strobe_off();
      wait_n(5);

      // R9: style change mid write (split to direction)
      proc_sel = 1'b0;
      latch_addr(8'd4);
      data_in = 8'h99;
      strobe_on(1'b0, 1'b0);
      wait_n(5);
      proc_sel = 1'b1;
      wait_n(5);
      strobe_off();
      wait_n(5);
      do_read(1'b0, 8'd4, v, oe);
      check("R9 style change aborts split write", v, mem[4]);

      // R9: style change mid write (direction to split, strobe stays low)
      proc_sel = 1'b1;
      latch_addr(8'd4);
      data_in = 8'h3C;
      strobe_on(1'b1, 1'b0);
      wait_n(5);
      proc_sel = 1'b0;
      wait_n(5);
      strobe_off();
      wait_n(5);
      do_read(1'b1, 8'd4, v, oe);
      check("R9 style change aborts dir write", v, mem[4]);

      // R9: hardware mode entered mid write
      proc_sel = 1'b0;
      latch_addr(8'd4);
      data_in = 8'hE1;
      strobe_on(1'b0, 1'b0);
      wait_n(5);
      hw_mode = 1'b1;
      wait_n(5);
      strobe_off();
      wait_n(5);
      hw_mode = 1'b0;
      wait_n(5);
      do_read(1'b0, 8'd4, v, oe);
      check("R9 mode change aborts write", v, mem[4]);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule